// File: doc/BRIEF.md
# Serial Codec Control Port

This block is the slave end of a four-wire serial control link for an audio codec. An external host frames each transfer with an active-low select line. It clocks in one 16-bit word, most significant bit first, on the rising edges of a serial clock. A word can write one of a small bank of control registers, or ask for a value to be read back. That value is either a control register or one of the peak-detector levels coming from the converter logic.

The serial clock has no fixed relation to the core clock that runs the converters. Shifting and framing therefore run on the serial clock and on the select line itself. Each complete word is handed to the core domain by flipping a toggle. The core domain synchronizes the toggle and turns each flip into exactly one decode. Register writes, the write strobe toward the converter logic and the read-back capture all happen in the core domain. A read captures its value there, and the value is shifted out on the serial output during the following frame.

Word layout: bits 15..12 are the address, bit 11 is the read flag (1 = read, 0 = write), and bits 10..0 are write data. Addresses 0..NUM_REGS-1 are control registers. The next NUM_PEAKS addresses are the peak levels, which are read-only. The frame after a host deasserts select must start no sooner than a handful of core cycles later.

Top module: `codec_ctl_port`

## Requirements
- R1: A frame of exactly 16 rising serial-clock edges with bit 11 = 0 and an address below NUM_REGS writes bits 10..0 into that control register, which then appears on `cfg_regs` at bits [addr*11 +: 11].
- R2: A frame with fewer or more than 16 serial-clock edges is discarded: no register changes, no strobe, and the read-back word is left as it was.
- R3: Every committed write raises `reg_wr_stb` for exactly one core cycle, carrying the address and data, and `cfg_regs` changes only in the cycle the strobe is high.
- R4: A committed read (bit 11 = 1) makes the next 16-bit frame shift out, MSB first, a word whose upper 5 bits are zero and whose low 11 bits are the addressed value. Addresses 0..NUM_REGS-1 return the control register, the next NUM_PEAKS addresses return the peak level zero-extended, and any higher address returns zero.
- R5: After a committed write, the next frame shifts out all zeros.
- R6: While select is high, `sdo_oe` is low and `sdo` is driven low.
- R7: A write that commits while `init_busy` is high is dropped (no strobe, no change) and sets `wr_dropped`, which stays set until reset. Reads still work while busy.
- R8: Reset returns every control register to REG_DEFAULTS, clears `wr_dropped`, and makes the read-back word zero.
- R9: A write to an address at or above NUM_REGS, peak addresses included, produces no strobe and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-down) |
| cs_n | input | 1 | Active-low frame select / latch line |
| sclk | input | 1 | Serial clock, data sampled on rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo, high only inside a frame |
| init_busy | input | 1 | High while the post-reset memory clear runs |
| peak_lvl | input | NUM_PEAKS*PEAK_W | Peak-detector levels, channel j at [j*PEAK_W +: PEAK_W] |
| cfg_regs | output | NUM_REGS*11 | Control register bank, register i at [i*11 +: 11] |
| reg_wr_stb | output | 1 | One-cycle pulse per applied write |
| reg_wr_addr | output | 4 | Address of the applied write |
| reg_wr_data | output | 11 | Data of the applied write |
| wr_dropped | output | 1 | Sticky flag: a write arrived while busy |

## Verification
The bench sends 15- and 17-edge frames that carry valid write words. A design that counted modulo 16, or committed on the sixteenth edge, would apply them. Every frame is followed by many core cycles, so a handshake that produced a level instead of a single pulse would show as a second strobe that the model does not expect. Reads are chained back to back across control, peak and unmapped addresses, and a write follows each read. This exposes a read-back word that is not refreshed or not cleared. Busy-time writes, peak-address writes and a second reset mid-run catch a drop flag that is not sticky, writes that leak through, and defaults that are not restored.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 11;
    localparam int CNT_W  = 5;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic [DATA_W-1:0] data;
    } ccp_word_t;
endpackage

// File: rtl/ccp_serial_rx.sv
module ccp_serial_rx
    import ccp_pkg::*;
(
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic [WORD_W-1:0] tx_word,
    output logic              sdo,
    output logic              sdo_oe,
    output ccp_word_t         hold_word,
    output logic              frame_tgl
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
    } rx_t;

    typedef struct packed {
        ccp_word_t word;
        logic      tgl;
    } cm_t;

    rx_t  rx_d, rx_q;
    cm_t  cm_d, cm_q;
    logic frame_rst_n;

    assign frame_rst_n = rst_n & ~cs_n;

    // shift stage: counts edges, saturating one past a full word
    always_comb begin
        rx_d       = rx_q;
        rx_d.shift = {rx_q.shift[WORD_W-2:0], sdi};
        if (rx_q.cnt != OVER_CNT)
            rx_d.cnt = rx_q.cnt + 1'b1;
    end

    always_ff @(posedge sclk or negedge frame_rst_n) begin
        if (!frame_rst_n) rx_q <= '0;
        else              rx_q <= rx_d;
    end

    // commit stage: runs on the closing edge of the select line
    always_comb begin
        cm_d = cm_q;
        if (rx_q.cnt == FULL_CNT) begin
            cm_d.word = ccp_word_t'(rx_q.shift);
            cm_d.tgl  = ~cm_q.tgl;
        end
    end

    always_ff @(posedge cs_n or negedge rst_n) begin
        if (!rst_n) cm_q <= '0;
        else        cm_q <= cm_d;
    end

    always_comb begin
        sdo = 1'b0;
        if (!cs_n && rx_q.cnt < FULL_CNT)
            sdo = tx_word[4'd15 - rx_q.cnt[3:0]];
    end

    assign sdo_oe    = ~cs_n;
    assign hold_word = cm_q.word;
    assign frame_tgl = cm_q.tgl;
endmodule

// File: rtl/ccp_toggle_sync.sv
module ccp_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic [STAGES:0] sync_d, sync_q;

    always_comb sync_d = {sync_q[STAGES-1:0], tgl_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pulse = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/ccp_reg_bank.sv
module ccp_reg_bank
    import ccp_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int NUM_PEAKS = 4,
    parameter int PEAK_W    = 8,
    parameter logic [NUM_REGS*DATA_W-1:0] REG_DEFAULTS = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  ccp_word_t                     cmd,
    input  logic                          init_busy,
    input  logic [NUM_PEAKS*PEAK_W-1:0]   peak_lvl,
    output logic [NUM_REGS*DATA_W-1:0]    cfg_regs,
    output logic                          wr_stb,
    output logic [ADDR_W-1:0]             wr_addr,
    output logic [DATA_W-1:0]             wr_data,
    output logic [WORD_W-1:0]             rd_word,
    output logic                          wr_dropped
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            stb;
        logic [ADDR_W-1:0]               waddr;
        logic [DATA_W-1:0]               wdata;
        logic [WORD_W-1:0]               rd_word;
        logic                            dropped;
    } bank_t;

    bank_t             bk_d, bk_q;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (int'(cmd.addr) == i) rd_val = bk_q.regs[i];
        for (int j = 0; j < NUM_PEAKS; j++)
            if (int'(cmd.addr) == NUM_REGS + j)
                rd_val = DATA_W'(peak_lvl[j*PEAK_W +: PEAK_W]);
    end

    always_comb begin
        bk_d     = bk_q;
        bk_d.stb = 1'b0;
        if (cmd_valid) begin
            if (cmd.rd) begin
                bk_d.rd_word = WORD_W'(rd_val);
            end else begin
                bk_d.rd_word = '0;
                if (init_busy) begin
                    bk_d.dropped = 1'b1;
                end else if (int'(cmd.addr) < NUM_REGS) begin
                    bk_d.regs[cmd.addr] = cmd.data;
                    bk_d.stb            = 1'b1;
                    bk_d.waddr          = cmd.addr;
                    bk_d.wdata          = cmd.data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q      <= '0;
            bk_q.regs <= REG_DEFAULTS;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign cfg_regs   = bk_q.regs;
    assign wr_stb     = bk_q.stb;
    assign wr_addr    = bk_q.waddr;
    assign wr_data    = bk_q.wdata;
    assign rd_word    = bk_q.rd_word;
    assign wr_dropped = bk_q.dropped;
endmodule

// File: rtl/codec_ctl_port.sv
module codec_ctl_port
    import ccp_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int NUM_PEAKS   = 4,
    parameter int PEAK_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_REGS*DATA_W-1:0] REG_DEFAULTS = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        sclk,
    input  logic                        sdi,
    output logic                        sdo,
    output logic                        sdo_oe,
    input  logic                        init_busy,
    input  logic [NUM_PEAKS*PEAK_W-1:0] peak_lvl,
    output logic [NUM_REGS*DATA_W-1:0]  cfg_regs,
    output logic                        reg_wr_stb,
    output logic [ADDR_W-1:0]           reg_wr_addr,
    output logic [DATA_W-1:0]           reg_wr_data,
    output logic                        wr_dropped
);
    ccp_word_t         hold_word;
    logic              frame_tgl;
    logic              cmd_valid;
    logic [WORD_W-1:0] rd_word;

    ccp_serial_rx u_rx (
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .tx_word   (rd_word),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .hold_word (hold_word),
        .frame_tgl (frame_tgl)
    );

    ccp_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tgl_in (frame_tgl),
        .pulse  (cmd_valid)
    );

    ccp_reg_bank #(
        .NUM_REGS     (NUM_REGS),
        .NUM_PEAKS    (NUM_PEAKS),
        .PEAK_W       (PEAK_W),
        .REG_DEFAULTS (REG_DEFAULTS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd        (hold_word),
        .init_busy  (init_busy),
        .peak_lvl   (peak_lvl),
        .cfg_regs   (cfg_regs),
        .wr_stb     (reg_wr_stb),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_word    (rd_word),
        .wr_dropped (wr_dropped)
    );
endmodule

// File: rtl/ccp_checker.sv
module ccp_checker #(
    parameter int NUM_REGS = 8,
    parameter int CFG_W    = 88
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             init_busy,
    input logic             reg_wr_stb,
    input logic [3:0]       reg_wr_addr,
    input logic [CFG_W-1:0] cfg_regs,
    input logic             wr_dropped
);
    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |=> !reg_wr_stb);

    // R3
    regs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_stb |-> $stable(cfg_regs));

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |-> $past(!init_busy));

    // R7
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dropped |=> wr_dropped);

    // R9
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |-> (int'(reg_wr_addr) < NUM_REGS));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sdo_oe && !sdo));
endmodule

bind codec_ctl_port ccp_checker #(
    .NUM_REGS (NUM_REGS),
    .CFG_W    (NUM_REGS*ccp_pkg::DATA_W)
) u_ccp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .init_busy   (init_busy),
    .reg_wr_stb  (reg_wr_stb),
    .reg_wr_addr (reg_wr_addr),
    .cfg_regs    (cfg_regs),
    .wr_dropped  (wr_dropped)
);

// File: tb/test_codec_ctl_port.sv
module test_codec_ctl_port;
    localparam int NREG = 8;
    localparam int NPK  = 4;
    localparam int PW   = 8;
    localparam int DW   = 11;

    function automatic logic [NREG*DW-1:0] mk_defaults();
        logic [NREG*DW-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*DW +: DW] = DW'(16'h0A0 + i * 7);
        return v;
    endfunction
    localparam logic [NREG*DW-1:0] DEFS = mk_defaults();

    logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0, init_busy = 0;
    logic sdo, sdo_oe, reg_wr_stb, wr_dropped;
    logic [NPK*PW-1:0]  peak_lvl;
    logic [NREG*DW-1:0] cfg_regs;
    logic [3:0]         reg_wr_addr;
    logic [DW-1:0]      reg_wr_data;

    codec_ctl_port #(.NUM_REGS(NREG), .NUM_PEAKS(NPK), .PEAK_W(PW),
                     .REG_DEFAULTS(DEFS)) i_codec_ctl_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .init_busy(init_busy), .peak_lvl(peak_lvl),
        .cfg_regs(cfg_regs), .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .wr_dropped(wr_dropped));

    always #2 clk = ~clk;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [DW-1:0] m_regs [NREG];
    logic          m_drop;
    logic [15:0]   m_tx;
    logic [14:0]   exp_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] peak(input int j);
        return DW'(peak_lvl[j*PW +: PW]);
    endfunction

    function automatic logic [15:0] m_read(input int a);
        if (a < NREG) return 16'(m_regs[a]);
        if (a < NREG + NPK) return 16'(peak(a - NREG));
        return 16'h0;
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) if (rst_n && !done) begin
        if (reg_wr_stb) begin
            if (exp_q.size() == 0) chk(0, "R3 unexpected strobe", int'(reg_wr_addr), 0);
            else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                chk({reg_wr_addr, reg_wr_data} == e, "R3 strobe addr/data",
                    int'({reg_wr_addr, reg_wr_data}), int'(e));
                m_regs[e[14:11]] = e[10:0];
            end
        end
        for (int i = 0; i < NREG; i++)
            chk(cfg_regs[i*DW +: DW] == m_regs[i], "R1 cfg_regs vs model",
                int'(cfg_regs[i*DW +: DW]), int'(m_regs[i]));
        if (cs_n) chk(!sdo_oe && !sdo, "R6 idle output", int'({sdo_oe, sdo}), 0);
    end

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        for (int i = 0; i < NREG; i++) m_regs[i] = DEFS[i*DW +: DW];
        m_drop = 0; m_tx = 0; exp_q.delete();
        #1 rst_n = 1;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic frame(input logic [15:0] w, input int nbits, output logic [15:0] rx);
        rx = '0;
        cs_n = 0; #9;
        for (int k = 0; k < nbits; k++) begin
            sdi = (k < 16) ? w[15-k] : 1'b0;
            #17;
            if (k < 16) rx[15-k] = sdo;
            chk(sdo_oe, "R6 oe in frame", int'(sdo_oe), 1);
            sclk = 1; #17; sclk = 0;
        end
        #9; cs_n = 1;
        repeat (24) @(posedge clk);
        #1;
    endtask

    // send a word; nbits != 16 makes it an aborted frame
    task automatic send(input logic [3:0] a, input bit rd, input logic [10:0] d,
                        input int nbits, input string req);
        logic [15:0] rx, w, prev_tx;
        w = {a, rd, d};
        prev_tx = m_tx;
        if (nbits == 16) begin
            if (rd) m_tx = m_read(int'(a));
            else begin
                m_tx = 0;
                if (init_busy) m_drop = 1;
                else if (int'(a) < NREG) exp_q.push_back({a, d});
            end
        end
        frame(w, nbits, rx);
        if (nbits == 16) chk(rx == prev_tx, req, int'(rx), int'(prev_tx));
        chk(exp_q.size() == 0, "R3 exactly one strobe per write", exp_q.size(), 0);
        chk(wr_dropped == m_drop, "R7 drop flag", int'(wr_dropped), int'(m_drop));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            chk(0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < NPK; j++) peak_lvl[j*PW +: PW] = PW'(8'h30 + j * 8'h11);
        do_reset();
        // R8 reset state
        for (int i = 0; i < NREG; i++)
            chk(cfg_regs[i*DW +: DW] == DEFS[i*DW +: DW], "R8 default after reset",
                int'(cfg_regs[i*DW +: DW]), int'(DEFS[i*DW +: DW]));
        chk(!wr_dropped, "R8 drop flag clear", int'(wr_dropped), 0);

        // R1 writes
        send(4'd3, 0, 11'h5A5, 16, "R8 first frame shifts zero");
        send(4'd7, 0, 11'h7FF, 16, "R5 after write");
        send(4'd0, 0, 11'h001, 16, "R5 after write");
        // R4 chained reads
        send(4'd3, 1, 11'h0, 16, "R5 after write");
        send(4'd7, 1, 11'h0, 16, "R4 read reg3");
        send(4'd8, 1, 11'h0, 16, "R4 read reg7");
        send(4'd11, 1, 11'h0, 16, "R4 read peak0");
        send(4'd14, 1, 11'h0, 16, "R4 read peak3");
        send(4'd1, 0, 11'h2AA, 16, "R4 read unmapped");
        // R2 aborted frames
        send(4'd2, 0, 11'h123, 15, "R2 short frame");
        send(4'd2, 0, 11'h123, 17, "R2 long frame");
        send(4'd2, 1, 11'h0, 16, "R2 abort keeps tx word");
        send(4'd9, 0, 11'h456, 16, "R2 reg2 unchanged");
        // R9 write to peak address ignored
        send(4'd9, 1, 11'h0, 16, "R5 after ignored write");
        send(4'd15, 0, 11'h3C3, 16, "R9 peak1 unaffected");
        // R7 busy drop
        init_busy = 1;
        send(4'd4, 0, 11'h0F0, 16, "R5 before busy write");
        send(4'd4, 1, 11'h0, 16, "R7 after dropped write");
        init_busy = 0;
        send(4'd5, 0, 11'h155, 16, "R7 reg4 kept default");
        send(4'd5, 1, 11'h0, 16, "R7 write after busy");
        send(4'd0, 1, 11'h0, 16, "R4 read reg5");
        // R8 reset again
        do_reset();
        for (int i = 0; i < NREG; i++)
            chk(cfg_regs[i*DW +: DW] == DEFS[i*DW +: DW], "R8 defaults restored",
                int'(cfg_regs[i*DW +: DW]), int'(DEFS[i*DW +: DW]));
        chk(!wr_dropped, "R8 drop flag cleared", int'(wr_dropped), 0);
        send(4'd6, 1, 11'h0, 16, "R8 tx word zero after reset");
        send(4'd6, 0, 11'h011, 16, "R4 read reg6 default");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule